// File: doc/BRIEF.md
# Microcontroller Watchdog Supervisor

This block checks that the external controller steering a motor gate driver is still running. Software arms it by writing a one to an enable bit through the register-access port. From then on a down-counter runs over one of four interval lengths, picked by a two-bit interval select. The controller must read status register address 0x01 before the count runs out. Each such read restarts the count at the full selected interval.

If the count runs out, the block trips. It latches a fault that forces the gate outputs to their safe state and pulls the active-low alarm line low. It also drops the power-good output for a fixed number of cycles, which resets the controller. It clears its own enable bit and sets a sticky tripped flag. The fault, the safe state, the alarm and the tripped flag stay in place until an explicit fault-clear command. Supervision resumes only when software writes the enable bit again.

Top module: `mcu_wdog_supervisor`

## Requirements
- R1: Out of reset `sup_en`=0, `sup_tripped`=0, `alarm_n`=1, `gate_safe`=0 and `power_ok`=1.
- R2: A write (`wr_en`=1) to address 0x02 with `wr_data`=1 while `sup_en`=0 sets `sup_en` and loads the count with the interval chosen by `intv_sel` (0→INTV0, 1→INTV1, 2→INTV2, 3→INTV3). With no restart, `alarm_n` falls exactly that many clock edges after the enabling edge.
- R3: A read (`rd_en`=1) of address 0x01 while enabled restarts the count, so the trip comes a full interval after that read's edge. Reads of other addresses and writes to 0x01 do not restart the count.
- R4: On a trip `gate_safe` goes to 1 and `alarm_n` to 0. Both hold until a cycle with `fault_clr`=1, after which they return to 0 and 1.
- R5: On a trip `power_ok` goes low at the trip edge for exactly PULSE_CYC cycles and then returns high. Writes to the enable bit during the pulse do not change its length.
- R6: A trip clears `sup_en`, and no further trip happens until software enables the block again.
- R7: `sup_tripped` is set by a trip and stays set when the block is re-enabled. It is cleared only by `fault_clr`.
- R8: A restart read that falls in the same cycle as the last count step wins: no trip happens, and the count is reloaded.
- R9: A `fault_clr` in the same cycle as a trip loses: the trip is still latched.
- R10: Writing 0 to the enable bit stops the count, so no trip follows. Writing 1 while already enabled does not reload the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| rd_en | input | 1 | Register read strobe, one cycle |
| addr | input | ADDR_W | Register address of the access |
| wr_data | input | 1 | Value written to the enable bit at address 0x02 |
| intv_sel | input | 2 | Interval select, sampled when the count loads |
| fault_clr | input | 1 | Fault-clear command, one cycle |
| sup_en | output | 1 | Enable bit state |
| sup_tripped | output | 1 | Sticky tripped flag |
| alarm_n | output | 1 | Active-low fault line |
| gate_safe | output | 1 | Gate outputs forced to safe state |
| power_ok | output | 1 | Power-good; low during the controller reset pulse |

## Verification
Two functions can land in the same cycle as the trip. One is a restart read issued exactly when the count makes its final step. The other is a fault-clear issued on the very edge that trips. The bench provokes each one by issuing the access exactly interval-minus-one cycles after the enabling edge. For the read, it judges that no trip appears and that the next trip comes one full interval after the read. For the clear, it judges that the alarm still falls on the expected edge and stays latched.

// File: rtl/wdog_pkg.sv
// Package: shared definitions for the watchdog supervisor.
// Assumes: four interval choices, chosen by a two-bit select.
package wdog_pkg;
    typedef enum logic [1:0] {
        INTV_A = 2'd0,
        INTV_B = 2'd1,
        INTV_C = 2'd2,
        INTV_D = 2'd3
    } intv_sel_e;

    // Register-port events decoded from one access.
    typedef struct packed {
        logic kick;     // restart read of the status address
        logic ctl_wr;   // write to the enable register
        logic ctl_val;  // value written to the enable bit
    } bus_evt_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/wdog_decode.sv
// Module: wdog_decode
// Turns register-port strobes into watchdog events.
// Assumes: each strobe lasts one cycle, and read and write are not both set.
module wdog_decode
    import wdog_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int KICK_ADDR = 1,
    parameter int CTL_ADDR  = 2
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_data,
    output bus_evt_t          evt
);
    localparam logic [ADDR_W-1:0] KICK_A = ADDR_W'(KICK_ADDR);
    localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(CTL_ADDR);

    // Purpose: match each access against the two addresses the watchdog uses.
    always_comb begin
        evt.kick    = rd_en && (addr == KICK_A);
        evt.ctl_wr  = wr_en && (addr == CTL_A);
        evt.ctl_val = wr_data;
    end
endmodule

// File: rtl/wdog_enable.sv
// Module: wdog_enable
// Holds the enable bit. It signals a count load on a 0-to-1 write.
// Assumes: a trip in the same cycle as a write wins and clears the bit.
module wdog_enable
    import wdog_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_evt_t evt,
    input  logic     expire,
    output logic     en,
    output logic     load
);
    // Purpose: a load happens only when the block goes from off to on.
    always_comb begin
        load = evt.ctl_wr && evt.ctl_val && !en;
    end

    // Purpose: enable register; software sets or clears it, a trip clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0;
        end else if (expire) begin
            en <= 1'b0;
        end else if (evt.ctl_wr) begin
            en <= evt.ctl_val;
        end
    end
endmodule

// File: rtl/wdog_timer.sv
// Module: wdog_timer
// Down-counter over the selected interval. It flags the trip on the last step.
// Assumes: each interval is at least 1. The select is only sampled at a load or restart.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int INTV0 = 500000,
    parameter int INTV1 = 1000000,
    parameter int INTV2 = 2500000,
    parameter int INTV3 = 5000000,
    parameter int CNT_W = 23
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      load,
    input  logic      kick,
    input  intv_sel_e sel,
    output logic      expire
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload;

    // Purpose: pick the reload value for the current select.
    always_comb begin
        case (sel)
            INTV_A:  reload = CNT_W'(INTV0);
            INTV_B:  reload = CNT_W'(INTV1);
            INTV_C:  reload = CNT_W'(INTV2);
            default: reload = CNT_W'(INTV3);
        endcase
    end

    // Purpose: trip on the final step unless a restart read arrives in the same cycle.
    always_comb begin
        expire = en && !kick && (cnt == CNT_W'(1));
    end

    // Purpose: load, restart or step the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load || (en && kick)) begin
            cnt <= reload;
        end else if (en && (cnt != '0)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/wdog_pulse.sv
// Module: wdog_pulse
// Holds power-good low for a fixed number of cycles after each trip.
// Assumes: a trip during a running pulse restarts it at the full length.
module wdog_pulse #(
    parameter int PULSE_CYC = 3200,
    parameter int PW        = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic power_ok
);
    logic [PW-1:0] left;

    // Purpose: count the cycles of the low pulse that remain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
        end else if (start) begin
            left <= PW'(PULSE_CYC);
        end else if (left != '0) begin
            left <= left - PW'(1);
        end
    end

    // Purpose: power-good is high whenever no pulse is running.
    always_comb begin
        power_ok = (left == '0);
    end
endmodule

// File: rtl/wdog_fault.sv
// Module: wdog_fault
// Latches the trip into the safe state, the alarm and the sticky flag.
// Assumes: a trip wins over a clear in the same cycle.
module wdog_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic gate_safe,
    output logic alarm_n,
    output logic tripped
);
    logic latched;
    logic sticky;

    // Purpose: fault latch that drives the safe state and the alarm line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched <= 1'b0;
        end else if (set) begin
            latched <= 1'b1;
        end else if (clr) begin
            latched <= 1'b0;
        end
    end

    // Purpose: status flag that survives re-enabling, for software to read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= 1'b0;
        end else if (set) begin
            sticky <= 1'b1;
        end else if (clr) begin
            sticky <= 1'b0;
        end
    end

    // Purpose: drive the output polarities.
    always_comb begin
        gate_safe = latched;
        alarm_n   = !latched;
        tripped   = sticky;
    end
endmodule

// File: rtl/mcu_wdog_supervisor.sv
// Module: mcu_wdog_supervisor (top)
// Watchdog on an external controller. Enabled by a register write,
// restarted by reads of the status address. On a trip it latches a fault,
// pulses power-good low, and disables itself.
// Assumes: the register port is already synchronous to clk.
module mcu_wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int KICK_ADDR = 1,
    parameter int CTL_ADDR  = 2,
    parameter int INTV0     = 500000,
    parameter int INTV1     = 1000000,
    parameter int INTV2     = 2500000,
    parameter int INTV3     = 5000000,
    parameter int PULSE_CYC = 3200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_data,
    input  logic [1:0]        intv_sel,
    input  logic              fault_clr,
    output logic              sup_en,
    output logic              sup_tripped,
    output logic              alarm_n,
    output logic              gate_safe,
    output logic              power_ok
);
    localparam int MAX_INTV = max_of4(INTV0, INTV1, INTV2, INTV3);
    localparam int CNT_W    = $clog2(MAX_INTV + 1);
    localparam int PW       = (PULSE_CYC > 1) ? $clog2(PULSE_CYC + 1) : 1;

    bus_evt_t evt;
    logic     load;
    logic     expire;

    wdog_decode #(
        .ADDR_W   (ADDR_W),
        .KICK_ADDR(KICK_ADDR),
        .CTL_ADDR (CTL_ADDR)
    ) u_decode (
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wr_data(wr_data),
        .evt    (evt)
    );

    wdog_enable u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .expire(expire),
        .en    (sup_en),
        .load  (load)
    );

    wdog_timer #(
        .INTV0(INTV0),
        .INTV1(INTV1),
        .INTV2(INTV2),
        .INTV3(INTV3),
        .CNT_W(CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sup_en),
        .load  (load),
        .kick  (evt.kick),
        .sel   (intv_sel_e'(intv_sel)),
        .expire(expire)
    );

    generate
        if (PULSE_CYC > 0) begin : g_pulse
            wdog_pulse #(
                .PULSE_CYC(PULSE_CYC),
                .PW       (PW)
            ) u_pulse (
                .clk     (clk),
                .rst_n   (rst_n),
                .start   (expire),
                .power_ok(power_ok)
            );
        end else begin : g_no_pulse
            assign power_ok = 1'b1;
        end
    endgenerate

    wdog_fault u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (expire),
        .clr      (fault_clr),
        .gate_safe(gate_safe),
        .alarm_n  (alarm_n),
        .tripped  (sup_tripped)
    );
endmodule

// File: rtl/wdog_checker.sv
// Module: wdog_checker
// Temporal checks on the supervisor's ports, attached to it with a bind.
// Assumes: it sees the same clock and reset as the supervisor.
module wdog_checker #(
    parameter int ADDR_W    = 7,
    parameter int KICK_ADDR = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              fault_clr,
    input logic              sup_en,
    input logic              sup_tripped,
    input logic              alarm_n,
    input logic              power_ok
);
    // R2: a trip only comes out of the enabled state.
    a_r2_trip_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_n) |-> $past(sup_en));

    // R4: the alarm holds until a clear.
    a_r4_alarm_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_n && !fault_clr) |=> !alarm_n);

    // R5: the power-good pulse starts on the trip edge.
    a_r5_pulse_on_trip: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_n) |-> !power_ok);

    // R6: a trip clears the enable bit.
    a_r6_enable_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_n) |-> !sup_en);

    // R7: the tripped flag holds until a clear.
    a_r7_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_tripped && !fault_clr) |=> sup_tripped);

    // R8: a restart read while enabled prevents a trip on the next edge.
    a_r8_kick_blocks_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == ADDR_W'(KICK_ADDR)) && sup_en) |=> !$fell(alarm_n));
endmodule

bind mcu_wdog_supervisor wdog_checker #(
    .ADDR_W   (ADDR_W),
    .KICK_ADDR(KICK_ADDR)
) u_wdog_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .addr       (addr),
    .fault_clr  (fault_clr),
    .sup_en     (sup_en),
    .sup_tripped(sup_tripped),
    .alarm_n    (alarm_n),
    .power_ok   (power_ok)
);

// File: tb/mcu_wdog_supervisor_bench.sv
`timescale 1ns/1ps
module mcu_wdog_supervisor_bench;
    localparam int ADDR_W = 7;
    localparam int I0 = 20, I1 = 30, I2 = 45, I3 = 60;
    localparam int PULSE = 16;

    // kind: 0 restart read @0x01, 1 read @0x03, 2 write @0x01, 3 write en=1, 4 write en=0, 5 fault_clr
    typedef struct packed {
        int sel;
        int m;
        int kind;
        int exp;
        int req;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{0, -1, 0, 20, 2},   // R2 interval 0
        '{1, -1, 0, 30, 2},   // R2 interval 1
        '{2, -1, 0, 45, 2},   // R2 interval 2
        '{3, -1, 0, 60, 2},   // R2 interval 3
        '{0,  5, 0, 26, 3},   // R3 restart read
        '{2, 10, 0, 56, 3},   // R3
        '{3,  0, 0, 61, 3},   // R3 restart on first cycle
        '{1, 29, 0, 60, 8},   // R8 restart read on last step
        '{0,  5, 1, 20, 3},   // R3 other address read ignored
        '{0,  5, 2, 20, 3},   // R3 write to 0x01 ignored
        '{1, 10, 3, 30, 10},  // R10 rewrite of 1 no reload
        '{1, 10, 4,  0, 10},  // R10 disable stops count
        '{0, 19, 5, 20, 9}    // R9 clear on trip edge loses
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_data = 1'b0;
    logic [1:0]        intv_sel = 2'd0;
    logic              fault_clr = 1'b0;
    logic              sup_en, sup_tripped, alarm_n, gate_safe, power_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    mcu_wdog_supervisor #(
        .ADDR_W(ADDR_W), .KICK_ADDR(1), .CTL_ADDR(2),
        .INTV0(I0), .INTV1(I1), .INTV2(I2), .INTV3(I3), .PULSE_CYC(PULSE)
    ) u_mcu_wdog_supervisor (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .intv_sel(intv_sel), .fault_clr(fault_clr),
        .sup_en(sup_en), .sup_tripped(sup_tripped), .alarm_n(alarm_n),
        .gate_safe(gate_safe), .power_ok(power_ok)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    task automatic drop_strobes();
        wr_en = 1'b0; rd_en = 1'b0; fault_clr = 1'b0;
    endtask

    task automatic write_en(input bit v);
        wr_en = 1'b1; addr = 7'd2; wr_data = v;
        @(negedge clk);
        drop_strobes();
    endtask

    // Clears a trip, waits out the pulse and leaves the outputs clean.
    task automatic recover();
        repeat (PULSE + 2) @(negedge clk);
        fault_clr = 1'b1;
        @(negedge clk);
        drop_strobes();
    endtask

    task automatic run_vec(input vec_t v);
        int e;
        bit seen;
        int limit;
        string tag;
        tag = $sformatf("R%0d", v.req);
        intv_sel = v.sel[1:0];
        write_en(1'b1);
        e = 0;
        seen = 1'b0;
        limit = (v.exp == 0) ? 150 : v.exp + 5;
        while (!seen && e < limit) begin
            if (e == v.m) begin
                case (v.kind)
                    0: begin rd_en = 1'b1; addr = 7'd1; end
                    1: begin rd_en = 1'b1; addr = 7'd3; end
                    2: begin wr_en = 1'b1; addr = 7'd1; wr_data = 1'b1; end
                    3: begin wr_en = 1'b1; addr = 7'd2; wr_data = 1'b1; end
                    4: begin wr_en = 1'b1; addr = 7'd2; wr_data = 1'b0; end
                    default: fault_clr = 1'b1;
                endcase
            end
            @(negedge clk);
            e++;
            drop_strobes();
            if (!alarm_n) seen = 1'b1;
        end
        if (v.exp == 0) begin
            check(!seen, tag, seen, 0);
            check(sup_en == 1'b0, tag, sup_en, 0);
        end else begin
            check(seen && e == v.exp, tag, e, v.exp);
            check(power_ok == 1'b0, "R5", power_ok, 0);
            check(sup_en == 1'b0, "R6", sup_en, 0);
            check(sup_tripped == 1'b1 && gate_safe == 1'b1, "R7", sup_tripped, 1);
            repeat (PULSE + 2) @(negedge clk);
            check(alarm_n == 1'b0 && gate_safe == 1'b1, "R4", alarm_n, 0);
            fault_clr = 1'b1;
            @(negedge clk);
            drop_strobes();
            check(alarm_n == 1'b1 && gate_safe == 1'b0 && sup_tripped == 1'b0,
                  "R4", alarm_n, 1);
        end
        @(negedge clk);
    endtask

    initial begin
        int low;
        repeat (3) @(negedge clk);
        check(sup_en == 0 && alarm_n == 1 && power_ok == 1, "R1", sup_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sup_en == 0 && sup_tripped == 0 && alarm_n == 1 && gate_safe == 0 && power_ok == 1,
              "R1", alarm_n, 1);

        for (int i = 0; i < 13; i++) begin
            run_vec(VECS[i]);
        end

        // R5: pulse length, unaffected by an enable write during it; R7: flag survives re-enable
        intv_sel = 2'd3;
        write_en(1'b1);
        repeat (I3) @(negedge clk);
        check(alarm_n == 1'b0, "R2", alarm_n, 0);
        low = 1;
        write_en(1'b1);
        if (!power_ok) low++;
        while (!power_ok && low < 100) begin
            @(negedge clk);
            if (!power_ok) low++;
        end
        check(low == PULSE, "R5", low, PULSE);
        check(sup_en == 1'b1 && sup_tripped == 1'b1, "R7", sup_tripped, 1);
        check(alarm_n == 1'b0, "R4", alarm_n, 0);
        write_en(1'b0);
        fault_clr = 1'b1;
        @(negedge clk);
        drop_strobes();
        check(sup_tripped == 1'b0, "R7", sup_tripped, 0);

        // R6: after a trip the block stays off with no further trip
        intv_sel = 2'd0;
        write_en(1'b1);
        repeat (I0) @(negedge clk);
        check(alarm_n == 1'b0 && sup_en == 1'b0, "R6", sup_en, 0);
        recover();
        repeat (100) @(negedge clk);
        check(alarm_n == 1'b1 && power_ok == 1'b1 && sup_en == 1'b0, "R6", alarm_n, 1);

        finish_run();
    end
endmodule